// File: doc/BRIEF.md
# Gateway Ownership Semaphore

This block holds the two registers that let several host functions agree on which of them currently owns a shared indirect access gateway. It sits behind a small 32-bit register read/write port addressed by byte offset from the start of a vendor-specific configuration capability. A header word at the base identifies the capability by its ID, so software can confirm it has found the right structure.

A function that wants the gateway first reads the semaphore and proceeds only when it reads zero. It then reads the token counter, writes the token it got into the semaphore and reads the semaphore back. It owns the gateway when the readback matches its token. The counter advances on every read and skips zero, so no two tokens in a row are equal and none is zero. A nonzero write lands only while the semaphore is free. A zero write always frees it.

Reads return their data one cycle after the request. Writes give no response.

Top module: `gw_owner_sem`

## Requirements
- R1: After reset the semaphore reads zero, `rsp_valid` is low, and the token counter holds zero, so the first counter read returns 1.
- R2: Each read of the counter at offset 0x08 advances it by one and returns the advanced value, zero-extended to 32 bits.
- R3: The counter never returns zero. After the value 2^CNT_W-1 the next read returns 1.
- R4: A read of the semaphore at offset 0x0C returns its current value and does not change it.
- R5: A nonzero write to the semaphore while it holds zero stores the written 32-bit value.
- R6: A nonzero write to the semaphore while it holds a nonzero value is ignored.
- R7: A write of zero to the semaphore clears it, whatever it held.
- R8: A read of offset 0x00 returns the capability ID 0x09 in bits 7:0, with all other bits zero.
- R9: Every read request produces exactly one cycle of `rsp_valid`, in the cycle after the request. Writes produce none.
- R10: Reads of any other offset return zero. Writes to offsets other than 0x0C, including the counter, change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A register access is presented this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte offset from the capability base |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data is valid this cycle |
| rsp_rdata | output | DATA_W | Read data, held until the next read response |

## Verification
The bench builds the block with `CNT_W = 4`, leaving the data and address widths at their defaults. The counter therefore wraps after fifteen tokens, and a full lap from reset is short enough to check that the skip over zero lands on 1. The 32-bit semaphore keeps its full width, so an all-ones contending write and small token values can both be checked against the claim and release rules.

// File: rtl/gw_sem_pkg.sv
// Package: shared offsets, identifiers and the decoded-access type
// for the gateway ownership semaphore.
package gw_sem_pkg;
    // Register byte offsets from the capability base.
    localparam int unsigned OFS_HDR = 'h00;
    localparam int unsigned OFS_CNT = 'h08;
    localparam int unsigned OFS_SEM = 'h0C;

    // Identifier reported in the header word, bits 7:0.
    localparam int unsigned CAP_IDENT = 'h09;

    // One decoded access; at most one hit flag is set.
    typedef struct packed {
        logic rd;       // read request this cycle
        logic wr;       // write request this cycle
        logic hit_hdr;  // header word addressed
        logic hit_cnt;  // token counter addressed
        logic hit_sem;  // semaphore addressed
    } gw_access_t;
endpackage

// File: rtl/gw_reg_decode.sv
// Module: gw_reg_decode
// Turns a raw request into a decoded access. Only exact byte offsets
// match; anything else is an unmapped access.
// Assumes: req_addr is stable while req_valid is high in a cycle.
module gw_reg_decode #(
    parameter int ADDR_W = 8
) (
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    output gw_sem_pkg::gw_access_t  acc
);
    import gw_sem_pkg::*;

    localparam logic [ADDR_W-1:0] A_HDR = ADDR_W'(OFS_HDR);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFS_CNT);
    localparam logic [ADDR_W-1:0] A_SEM = ADDR_W'(OFS_SEM);

    // Decode direction and target register.
    always_comb begin
        acc.rd      = req_valid && !req_write;
        acc.wr      = req_valid &&  req_write;
        acc.hit_hdr = (req_addr == A_HDR);
        acc.hit_cnt = (req_addr == A_CNT);
        acc.hit_sem = (req_addr == A_SEM);
    end
endmodule

// File: rtl/gw_token_counter.sv
// Module: gw_token_counter
// Token source. Advances by one on each counter read and skips zero,
// so a token handed out is never zero. token_next is the value the
// current read returns and the register holds after the edge.
// Assumes: CNT_W >= 2.
module gw_token_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    output logic [CNT_W-1:0] token_next
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] inc;

    // Compute the next token, stepping over zero at the wrap.
    always_comb begin
        inc        = cnt_q + ONE;
        token_next = (inc == '0) ? ONE : inc;
    end

    // Hold the last token handed out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (take)
            cnt_q <= token_next;
    end

    // R3: a taken token is never zero.
    p_token_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (cnt_q != '0));

    // R2: the counter moves only on a read.
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(cnt_q));
endmodule

// File: rtl/gw_sem_reg.sv
// Module: gw_sem_reg
// The ownership semaphore. Zero means free. A nonzero write lands
// only on a free semaphore; a zero write always frees it.
// Assumes: wr is a single-cycle qualified write strobe.
module gw_sem_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] sem
);
    logic is_free;
    logic release_req;

    // Classify the write against the current state.
    always_comb begin
        is_free     = (sem == '0);
        release_req = (wdata == '0);
    end

    // Apply the acceptance rule.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sem <= '0;
        else if (wr && (release_req || is_free))
            sem <= wdata;
    end

    // R5: a claim on a free semaphore stores the token.
    p_claim_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && is_free) |=> (sem == $past(wdata)));

    // R6: a nonzero write to a held semaphore leaves it unchanged.
    p_held_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !is_free && !release_req) |=> $stable(sem));

    // R7: a zero write always frees it.
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && release_req) |=> (sem == '0));

    // R4: without a write the semaphore holds.
    p_no_write_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(sem));
endmodule

// File: rtl/gw_owner_sem.sv
// Module: gw_owner_sem (top)
// Register pair that arbitrates ownership of a shared gateway: a
// header word with the capability ID, a zero-skipping token counter
// and a semaphore, on a 32-bit read/write port with one-cycle read
// latency.
// Assumes: CNT_W <= DATA_W and DATA_W >= 8.
module gw_owner_sem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    import gw_sem_pkg::*;

    localparam logic [DATA_W-1:0] HDR_WORD = DATA_W'(CAP_IDENT);

    gw_access_t        acc;
    logic [CNT_W-1:0]  token_next;
    logic [DATA_W-1:0] sem;
    logic [DATA_W-1:0] rd_mux;

    gw_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .acc       (acc)
    );

    gw_token_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (acc.rd && acc.hit_cnt),
        .token_next (token_next)
    );

    gw_sem_reg #(.DATA_W(DATA_W)) u_sem (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (acc.wr && acc.hit_sem),
        .wdata (req_wdata),
        .sem   (sem)
    );

    // Select the read data for the addressed register.
    always_comb begin
        if (acc.hit_hdr)
            rd_mux = HDR_WORD;
        else if (acc.hit_cnt)
            rd_mux = DATA_W'(token_next);
        else if (acc.hit_sem)
            rd_mux = sem;
        else
            rd_mux = '0;
    end

    // Register the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc.rd;
            if (acc.rd)
                rsp_rdata <= rd_mux;
        end
    end

    // R9: a read is answered in the next cycle.
    p_read_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R9: no response without a read.
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R8: a header read returns the identifier.
    p_header_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.rd && acc.hit_hdr) |=> (rsp_rdata == HDR_WORD));

    // At most one register is addressed at a time.
    p_onehot_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc.hit_hdr, acc.hit_cnt, acc.hit_sem}));
endmodule

// File: tb/gw_owner_sem_test.sv
// Directed bench for gw_owner_sem, one task per scenario.
module gw_owner_sem_test;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 4;
    localparam int LAP    = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic              req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;
    int exp_cnt = 0;

    gw_owner_sem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_cnt = 0;
    endtask

    // One read; checks the one-cycle response window (R9).
    task automatic do_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 rsp_valid after read", DATA_W'(rsp_valid), 1);
        d = rsp_rdata;
        @(negedge clk);
        check("R9 rsp_valid one cycle only", DATA_W'(rsp_valid), 0);
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R9 no response to write", DATA_W'(rsp_valid), 0);
    endtask

    task automatic read_cnt_expect(input string req);
        logic [DATA_W-1:0] d;
        exp_cnt = (exp_cnt == LAP) ? 1 : exp_cnt + 1;
        do_read(8'h08, d);
        check(req, d, DATA_W'(exp_cnt));
    endtask

    task automatic t_reset_state();
        logic [DATA_W-1:0] d;
        do_reset();
        check("R1 rsp_valid low after reset", DATA_W'(rsp_valid), 0);
        do_read(8'h0C, d);
        check("R1 semaphore zero after reset", d, 0);
        read_cnt_expect("R1 first token is 1");
    endtask

    task automatic t_counter_step();
        read_cnt_expect("R2 token step");
        read_cnt_expect("R2 token step");
    endtask

    task automatic t_header_and_unmapped();
        logic [DATA_W-1:0] d;
        do_read(8'h00, d);
        check("R8 header ID", d, 32'h0000_0009);
        do_read(8'h04, d);
        check("R10 unmapped read zero", d, 0);
        do_write(8'h08, 32'h5);
        do_write(8'h10, 32'h77);
        read_cnt_expect("R10 counter write ignored");
        do_read(8'h0C, d);
        check("R10 stray writes leave semaphore", d, 0);
    endtask

    task automatic t_claim();
        logic [DATA_W-1:0] d;
        logic [DATA_W-1:0] tok;
        do_read(8'h0C, d);
        check("R4 semaphore free before claim", d, 0);
        exp_cnt = exp_cnt + 1;
        do_read(8'h08, tok);
        check("R2 claim token", tok, DATA_W'(exp_cnt));
        do_write(8'h0C, tok);
        do_read(8'h0C, d);
        check("R5 claim readback", d, tok);
        do_read(8'h0C, d);
        check("R4 read has no side effect", d, tok);
    endtask

    task automatic t_contend();
        logic [DATA_W-1:0] d;
        do_write(8'h0C, 32'hAB);
        do_read(8'h0C, d);
        check("R6 contending write ignored", d, DATA_W'(exp_cnt));
        do_write(8'h0C, 32'hFFFF_FFFF);
        do_read(8'h0C, d);
        check("R6 all-ones write ignored", d, DATA_W'(exp_cnt));
    endtask

    task automatic t_release();
        logic [DATA_W-1:0] d;
        do_write(8'h0C, 32'h0);
        do_read(8'h0C, d);
        check("R7 release clears", d, 0);
        do_write(8'h0C, 32'h0);
        do_read(8'h0C, d);
        check("R7 release when free", d, 0);
        do_write(8'h0C, 32'hFFFF_FFFF);
        do_read(8'h0C, d);
        check("R5 wide claim after release", d, 32'hFFFF_FFFF);
        do_write(8'h0C, 32'h0);
        do_read(8'h0C, d);
        check("R7 release of wide value", d, 0);
    endtask

    task automatic t_wrap();
        do_reset();
        for (int i = 0; i < LAP; i++)
            read_cnt_expect("R3 lap token");
        read_cnt_expect("R3 wrap skips zero");
        read_cnt_expect("R3 after wrap");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_counter_step();
        t_header_and_unmapped();
        t_claim();
        t_contend();
        t_release();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule